// File: doc/BRIEF.md
# Fixed-Latency Arbitrated Line Memory

This block is a backing store built from a parameterised number of lines, each holding `WPL` words. Several requester ports share it. Every port can ask for a single word or a whole line, either to read or to write. Each port carries its own fixed requester identity, which is its port index. The memory serves one arbitrated request at a time. Every access costs the same configured latency of `DELAY` cycles, and a one-hot `rsp_ok` vector reports completion each cycle. A port that is valid and not flagged as complete is waiting.

When no port owns the memory, the lowest-numbered valid port takes a single ownership lock and starts a countdown. Every other port waits until that owner has been served. One port, the side-door port, skips both the lock and the countdown and completes in the cycle it presents. This port is meant for preloading and inspection by a supervising agent. Addresses are signed. They wrap into the word range, and negative values fold back into the positive range. A read-only debug port shows any line without touching arbitration.

Top module: `fixed_lat_line_mem`

## Requirements
- R1: A wrapped word address `w` selects line `w / WPL` and word `w % WPL`. Word `k` of a line occupies bits `[k*WORD_W +: WORD_W]`. Line operations ignore the word offset, so every address in a line returns or overwrites that same line. Operation codes on `req_op`: 0 is word read, 1 is word write, 2 is line read, 3 is line write.
- R2: An address `a` of `ADDR_W` bits is taken as two's complement and mapped to `((a mod M) + M) mod M`, where M = `LINES*WPL`. With M = 48, both -10 and -58 reach word 38, and 100 reaches word 4.
- R3: With `DELAY` N > 0, the owner sees N waiting cycles and completes on cycle N+1 of holding its request. A write changes memory only at the clock edge that ends its completing cycle.
- R4: With `DELAY` = 0, a request from the owner completes in the cycle in which it is first presented.
- R5: While the memory is unowned, the lowest-indexed valid non-side port takes ownership in that cycle. It keeps ownership until it completes.
- R6: Only the owner and the side-door port can complete. Every other valid port waits, and this includes the cycle in which the owner completes.
- R7: On the edge that ends the owner's completing cycle, the lock is released and the countdown reloads to N. A port refused in that cycle then needs N further waiting cycles, starting with the next cycle.
- R8: A side-door request completes in the cycle it is presented, whatever the lock state. It does not move the owner's countdown. Its write lands at the same edge and takes precedence over an owner write to the same word.
- R9: After reset, every stored word is zero and the memory is unowned.
- R10: `dbg_data` shows line `dbg_line`, or zero when that index is `LINES` or greater. It has no effect on any request.
- R11: Read data on a completing port reflects memory as it stood before that cycle's writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request present, one bit per port |
| req_op | input | 2*NREQ | Operation code per port (R1 encoding) |
| req_addr | input | ADDR_W*NREQ | Signed word address per port |
| req_wword | input | WORD_W*NREQ | Write word per port |
| req_wline | input | WPL*WORD_W*NREQ | Write line per port |
| rsp_ok | output | NREQ | Completion flag per port |
| rsp_word | output | WORD_W*NREQ | Read word per port |
| rsp_line | output | WPL*WORD_W*NREQ | Read line per port |
| dbg_line | input | clog2(LINES) | Line to observe |
| dbg_data | output | WPL*WORD_W | Observed line contents |

## Verification
The hardest situations to reach from the ports depend on exact cycle alignment. One is a contender refused in the very cycle its rival completes. Another is a side-door write that lands on the owner's completing edge. A third is an owner that drops its request mid-countdown while a zero-latency copy of the block runs on the same stimulus. The bench counts cycles from each request's start, so it can place the side-door write on a chosen cycle of the countdown and let two ports contend for the same line. A seeded traffic phase then mixes all four operations, negative and oversized addresses and side-door bursts. A cycle-by-cycle behavioural model checks every response and a rotating debug view against that traffic.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

    typedef enum logic [1:0] {
        OP_RD_WORD = 2'd0,
        OP_WR_WORD = 2'd1,
        OP_RD_LINE = 2'd2,
        OP_WR_LINE = 2'd3
    } lmem_op_e;

    function automatic logic op_is_write(input logic [1:0] op);
        return op[0];
    endfunction

    function automatic logic op_is_line(input logic [1:0] op);
        return op[1];
    endfunction

endpackage

// File: rtl/lmem_addr_wrap.sv
module lmem_addr_wrap #(
    parameter int ADDR_W    = 16,
    parameter int MEM_WORDS = 48,
    parameter int WPL       = 4,
    parameter int LIDX_W    = 4,
    parameter int WIDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [LIDX_W-1:0] line_o,
    output logic [WIDX_W-1:0] word_o
);
    localparam logic signed [ADDR_W:0] M_S   = (ADDR_W+1)'(MEM_WORDS);
    localparam logic        [ADDR_W:0] WPL_U = (ADDR_W+1)'(WPL);
    localparam logic        [ADDR_W:0] M_U   = (ADDR_W+1)'(MEM_WORDS);

    logic signed [ADDR_W:0] a_ext;
    logic signed [ADDR_W:0] rem;
    logic        [ADDR_W:0] pos;

    always_comb begin
        a_ext = $signed({addr_i[ADDR_W-1], addr_i});
        rem   = a_ext % M_S;
        if (rem < 0) begin
            rem = rem + M_S;
        end
        pos    = $unsigned(rem);
        line_o = LIDX_W'(pos / WPL_U);
        word_o = WIDX_W'(pos % WPL_U);
    end

    // folded address always lands inside the word range
    always_comb begin
        assert_wrap_range_R2: assert (pos < M_U);
    end

endmodule

// File: rtl/lmem_lock.sv
module lmem_lock #(
    parameter int NREQ  = 3,
    parameter int DELAY = 3,
    parameter int IDW   = 2,
    parameter int CNT_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_v,
    output logic [NREQ-1:0] ok_o,
    output logic            fire_o,
    output logic [IDW-1:0]  win_o
);
    typedef struct packed {
        logic             own_v;
        logic [IDW-1:0]   own;
        logic [CNT_W-1:0] cnt;
    } lock_s;

    lock_s          s_d, s_q;
    logic           eff_v;
    logic [IDW-1:0] eff_id;
    logic           fire;

    always_comb begin
        eff_v  = s_q.own_v;
        eff_id = s_q.own;
        if (!s_q.own_v) begin
            for (int i = NREQ - 1; i >= 0; i--) begin
                if (req_v[i]) begin
                    eff_v  = 1'b1;
                    eff_id = IDW'(i);
                end
            end
        end
        fire = eff_v && (s_q.cnt == '0) && req_v[eff_id];

        s_d = s_q;
        if (fire) begin
            s_d.own_v = 1'b0;
            s_d.cnt   = CNT_W'(DELAY);
        end else if (eff_v) begin
            s_d.own_v = 1'b1;
            s_d.own   = eff_id;
            if (s_q.cnt != '0) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{own_v: 1'b0, own: '0, cnt: CNT_W'(DELAY)};
        end else begin
            s_q <= s_d;
        end
    end

    assign ok_o   = fire ? (NREQ'(1) << eff_id) : '0;
    assign fire_o = fire;
    assign win_o  = eff_id;

    // completion releases the lock and reloads the full latency
    assert_release_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!s_q.own_v && s_q.cnt == CNT_W'(DELAY)));

    // a held lock keeps the same owner until it completes
    assert_owner_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.own_v && !fire) |=> (s_q.own_v && s_q.own == $past(s_q.own)));

    // countdown moves by exactly one per held cycle
    assert_countdown_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.own_v && s_q.cnt != '0) |=> (s_q.cnt == CNT_W'($past(s_q.cnt) - 1'b1)));

    generate
        if (DELAY > 0) begin : g_gap
            // no grant can follow a grant directly when latency is nonzero
            assert_no_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
                fire |=> (ok_o == '0));
        end
    endgenerate

endmodule

// File: rtl/lmem_store.sv
module lmem_store #(
    parameter int LINES  = 12,
    parameter int WORD_W = 32,
    parameter int WPL    = 4,
    parameter int LIDX_W = 4,
    parameter int WIDX_W = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               a_we,
    input  logic                               a_line_mode,
    input  logic [LIDX_W-1:0]                  a_line,
    input  logic [WIDX_W-1:0]                  a_word,
    input  logic [WORD_W-1:0]                  a_wword,
    input  logic [WPL*WORD_W-1:0]              a_wline,
    input  logic                               b_we,
    input  logic                               b_line_mode,
    input  logic [LIDX_W-1:0]                  b_line,
    input  logic [WIDX_W-1:0]                  b_word,
    input  logic [WORD_W-1:0]                  b_wword,
    input  logic [WPL*WORD_W-1:0]              b_wline,
    output logic [LINES-1:0][WPL*WORD_W-1:0]   mem_o
);
    localparam int LINE_W = WPL * WORD_W;

    logic [LINES-1:0][LINE_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        // owner first, side-door afterwards so that it wins a collision
        if (a_we) begin
            if (a_line_mode) mem_d[a_line] = a_wline;
            else             mem_d[a_line][a_word*WORD_W +: WORD_W] = a_wword;
        end
        if (b_we) begin
            if (b_line_mode) mem_d[b_line] = b_wline;
            else             mem_d[b_line][b_word*WORD_W +: WORD_W] = b_wword;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign mem_o = mem_q;

    // without a write strobe the contents never move
    assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_we && !b_we) |=> $stable(mem_q));

    // a side-door line write lands at the very next edge
    assert_side_line_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (b_we && b_line_mode) |=> (mem_q[$past(b_line)] == $past(b_wline)));

endmodule

// File: rtl/fixed_lat_line_mem.sv
module fixed_lat_line_mem #(
    parameter int NREQ      = 3,
    parameter int SIDE_PORT = 2,
    parameter int DELAY     = 3,
    parameter int LINES     = 12,
    parameter int WORD_W    = 32,
    parameter int WPL       = 4,
    parameter int ADDR_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NREQ-1:0]               req_valid,
    input  logic [2*NREQ-1:0]             req_op,
    input  logic [ADDR_W*NREQ-1:0]        req_addr,
    input  logic [WORD_W*NREQ-1:0]        req_wword,
    input  logic [WPL*WORD_W*NREQ-1:0]    req_wline,
    output logic [NREQ-1:0]               rsp_ok,
    output logic [WORD_W*NREQ-1:0]        rsp_word,
    output logic [WPL*WORD_W*NREQ-1:0]    rsp_line,
    input  logic [((LINES > 1) ? $clog2(LINES) : 1)-1:0] dbg_line,
    output logic [WPL*WORD_W-1:0]         dbg_data
);
    import lmem_pkg::*;

    localparam int LINE_W    = WPL * WORD_W;
    localparam int MEM_WORDS = LINES * WPL;
    localparam int LIDX_W    = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int WIDX_W    = (WPL > 1) ? $clog2(WPL) : 1;
    localparam int IDW       = (NREQ > 1) ? $clog2(NREQ) : 1;
    localparam int CNT_W     = (DELAY > 0) ? $clog2(DELAY + 1) : 1;
    localparam logic [NREQ-1:0] SIDE_MASK = NREQ'(1) << SIDE_PORT;

    logic [LIDX_W-1:0] line_idx [NREQ];
    logic [WIDX_W-1:0] word_idx [NREQ];
    logic [1:0]        op_a     [NREQ];
    logic [WORD_W-1:0] wword_a  [NREQ];
    logic [LINE_W-1:0] wline_a  [NREQ];

    logic [LINES-1:0][LINE_W-1:0] mem;
    logic [NREQ-1:0]              arb_ok;
    logic                         fire;
    logic [IDW-1:0]               win;

    genvar g;
    generate
        for (g = 0; g < NREQ; g++) begin : g_port
            assign op_a[g]    = req_op[g*2 +: 2];
            assign wword_a[g] = req_wword[g*WORD_W +: WORD_W];
            assign wline_a[g] = req_wline[g*LINE_W +: LINE_W];

            lmem_addr_wrap #(
                .ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS), .WPL(WPL),
                .LIDX_W(LIDX_W), .WIDX_W(WIDX_W)
            ) u_wrap (
                .addr_i (req_addr[g*ADDR_W +: ADDR_W]),
                .line_o (line_idx[g]),
                .word_o (word_idx[g])
            );

            assign rsp_line[g*LINE_W +: LINE_W] = mem[line_idx[g]];
            assign rsp_word[g*WORD_W +: WORD_W] =
                mem[line_idx[g]][word_idx[g]*WORD_W +: WORD_W];
        end
    endgenerate

    lmem_lock #(
        .NREQ(NREQ), .DELAY(DELAY), .IDW(IDW), .CNT_W(CNT_W)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_v  (req_valid & ~SIDE_MASK),
        .ok_o   (arb_ok),
        .fire_o (fire),
        .win_o  (win)
    );

    lmem_store #(
        .LINES(LINES), .WORD_W(WORD_W), .WPL(WPL),
        .LIDX_W(LIDX_W), .WIDX_W(WIDX_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .a_we        (fire && op_is_write(op_a[win])),
        .a_line_mode (op_is_line(op_a[win])),
        .a_line      (line_idx[win]),
        .a_word      (word_idx[win]),
        .a_wword     (wword_a[win]),
        .a_wline     (wline_a[win]),
        .b_we        (req_valid[SIDE_PORT] && op_is_write(op_a[SIDE_PORT])),
        .b_line_mode (op_is_line(op_a[SIDE_PORT])),
        .b_line      (line_idx[SIDE_PORT]),
        .b_word      (word_idx[SIDE_PORT]),
        .b_wword     (wword_a[SIDE_PORT]),
        .b_wline     (wline_a[SIDE_PORT]),
        .mem_o       (mem)
    );

    assign rsp_ok   = arb_ok | (req_valid & SIDE_MASK);
    assign dbg_data = ({1'b0, dbg_line} < (LIDX_W+1)'(LINES)) ? mem[dbg_line] : '0;

    // a side-door request is never left waiting
    assert_side_instant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[SIDE_PORT] |-> rsp_ok[SIDE_PORT]);

endmodule

// File: tb/fixed_lat_line_mem_tb.sv
module fixed_lat_line_mem_tb;
    import lmem_pkg::*;

    localparam int NREQ = 3, SIDE = 2, DLY = 3, LINES = 12, WPL = 4, MEMW = 48;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   req_valid = '0;
    logic [5:0]   req_op = '0;
    logic [47:0]  req_addr = '0;
    logic [95:0]  req_wword = '0;
    logic [383:0] req_wline = '0;
    logic [3:0]   dbg_line = '0;
    logic [2:0]   rsp_ok, zrsp_ok;
    logic [95:0]  rsp_word, zrsp_word;
    logic [383:0] rsp_line, zrsp_line;
    logic [127:0] dbg_data, zdbg_data;

    always #10 clk = ~clk;

    fixed_lat_line_mem u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wword(req_wword), .req_wline(req_wline),
        .rsp_ok(rsp_ok), .rsp_word(rsp_word), .rsp_line(rsp_line),
        .dbg_line(dbg_line), .dbg_data(dbg_data));

    fixed_lat_line_mem #(.DELAY(0)) u_dut_z (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wword(req_wword), .req_wline(req_wline),
        .rsp_ok(zrsp_ok), .rsp_word(zrsp_word), .rsp_line(zrsp_line),
        .dbg_line(dbg_line), .dbg_data(zdbg_data));

    int nchk = 0, nfail = 0;
    int a_int [NREQ];
    int op_i  [NREQ];
    logic [31:0]  ww [NREQ];
    logic [127:0] wl [NREQ];
    logic [31:0]  mw [MEMW];
    bit mown_v = 0;
    int mown = 0, mcnt = DLY, dbg_sel = 0, dbg_force = -1, seed = 7;
    logic [2:0]   last_ok, last_zok;
    logic [31:0]  last_word [NREQ];
    logic [127:0] last_line [NREQ];
    logic [127:0] last_dbg;
    logic [31:0]  last_zword1;

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic int wrapa(input int a);
        int r = a % MEMW;
        if (r < 0) r += MEMW;
        return r;
    endfunction

    function automatic logic [127:0] mline(input int l);
        return {mw[4*l+3], mw[4*l+2], mw[4*l+1], mw[4*l]};
    endfunction

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 32767;
    endfunction

    task automatic set_req(input int p, input bit v, input int o, input int a,
                           input logic [31:0] w, input logic [127:0] l);
        op_i[p] = o; a_int[p] = a; ww[p] = w; wl[p] = l;
        req_valid[p] = v;
        req_op[2*p +: 2] = 2'(o);
        req_addr[16*p +: 16] = a[15:0];
        req_wword[32*p +: 32] = w;
        req_wline[128*p +: 128] = l;
    endtask

    task automatic apply_write(input int p);
        int wa = wrapa(a_int[p]);
        int ln = wa / WPL;
        if (op_i[p] == OP_WR_WORD) mw[wa] = ww[p];
        else if (op_i[p] == OP_WR_LINE)
            for (int k = 0; k < WPL; k++) mw[4*ln+k] = wl[p][32*k +: 32];
    endtask

    // one clock: sample mid-low-phase, compare against model, advance model
    task automatic cyc();
        int eff = -1;
        bit fire;
        logic [2:0] expv = '0;
        int dl = (dbg_force >= 0) ? dbg_force : dbg_sel;
        dbg_line = 4'(dl);
        dbg_sel = (dbg_sel + 1) % 16;
        #5;
        last_ok = rsp_ok; last_zok = zrsp_ok; last_dbg = dbg_data;
        last_zword1 = zrsp_word[63:32];
        for (int p = 0; p < NREQ; p++) begin
            last_word[p] = rsp_word[32*p +: 32];
            last_line[p] = rsp_line[128*p +: 128];
        end
        if (mown_v) eff = mown;
        else for (int p = NREQ - 1; p >= 0; p--) if (p != SIDE && req_valid[p]) eff = p;
        fire = (eff >= 0) && (mcnt == 0) && req_valid[eff];
        if (fire) expv[eff] = 1'b1;
        if (req_valid[SIDE]) expv[SIDE] = 1'b1;
        chk("R6", "ok vector", 128'(last_ok), 128'(expv));
        for (int p = 0; p < NREQ; p++) begin
            if (expv[p] && op_i[p] == OP_RD_WORD)
                chk("R11", "read word", 128'(last_word[p]), 128'(mw[wrapa(a_int[p])]));
            if (expv[p] && op_i[p] == OP_RD_LINE)
                chk("R11", "read line", last_line[p], mline(wrapa(a_int[p]) / WPL));
        end
        chk("R10", "debug view", last_dbg, (dl < LINES) ? mline(dl) : 128'd0);
        if (fire) apply_write(eff);
        if (req_valid[SIDE]) apply_write(SIDE);
        if (fire) begin mown_v = 0; mcnt = DLY; end
        else if (eff >= 0) begin mown_v = 1; mown = eff; if (mcnt > 0) mcnt--; end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_until(input int p, output int n);
        n = 0;
        for (int i = 0; i < 60; i++) begin
            cyc();
            if (last_ok[p]) break;
            n++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int n, c0, c1;
        logic [127:0] la, lb;
        for (int i = 0; i < MEMW; i++) mw[i] = '0;
        for (int p = 0; p < NREQ; p++) set_req(p, 0, 0, 0, '0, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset contents and idle responses
        for (int l = 0; l < LINES; l++) begin
            dbg_line = 4'(l);
            #1 chk("R9", "reset line", dbg_data, 128'd0);
        end
        chk("R9", "reset ok", 128'(rsp_ok), 128'd0);

        // R3: word write latency, invisible until completion
        set_req(0, 1, OP_WR_WORD, 5, 32'h1111_0005, '0);
        dbg_force = 1;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            cyc();
            if (last_ok[0]) break;
            chk("R3", "write hidden", 128'(last_dbg[63:32]), 128'd0);
            n++;
        end
        chk("R3", "wait cycles", 128'(n), 128'(DLY));
        set_req(0, 0, 0, 0, '0, '0);
        cyc();
        chk("R3", "write visible", 128'(last_dbg[63:32]), 128'h1111_0005);
        dbg_force = -1;

        // R5/R6/R7: two contenders on the same line
        la = {32'hA3, 32'hA2, 32'hA1, 32'hA0};
        lb = {32'hB3, 32'hB2, 32'hB1, 32'hB0};
        set_req(0, 1, OP_WR_LINE, 8, '0, la);
        set_req(1, 1, OP_WR_LINE, 9, '0, lb);
        c0 = -1; c1 = -1;
        for (int c = 0; c < 40; c++) begin
            cyc();
            if (last_ok[0]) begin
                c0 = c;
                chk("R6", "refused on owner ok", 128'(last_ok[1]), 128'd0);
                set_req(0, 0, 0, 0, '0, '0);
            end
            if (last_ok[1]) begin c1 = c; break; end
        end
        set_req(1, 0, 0, 0, '0, '0);
        chk("R5", "lowest port first", 128'(c0), 128'(DLY));
        chk("R7", "full relatency", 128'(c1), 128'(c0 + 1 + DLY));
        dbg_force = 2; cyc(); dbg_force = -1;
        chk("R1", "line overwritten", last_dbg, lb);

        // R1: offsets within a line
        set_req(1, 1, OP_RD_LINE, 11, '0, '0); run_until(1, n);
        chk("R1", "line read offset 3", last_line[1], lb);
        set_req(1, 1, OP_RD_LINE, 10, '0, '0); run_until(1, n);
        chk("R1", "line read offset 2", last_line[1], lb);
        set_req(1, 1, OP_RD_WORD, 11, '0, '0); run_until(1, n);
        chk("R1", "word select", 128'(last_word[1]), 128'hB3);
        set_req(1, 0, 0, 0, '0, '0);

        // R2: negative and oversized addresses
        set_req(0, 1, OP_WR_WORD, -10, 32'hC0DE_0026, '0); run_until(0, n);
        set_req(0, 0, 0, 0, '0, '0);
        dbg_force = 9; cyc(); dbg_force = -1;
        chk("R2", "-10 to 38", 128'(last_dbg[95:64]), 128'hC0DE_0026);
        set_req(1, 1, OP_RD_WORD, -58, '0, '0); run_until(1, n);
        chk("R2", "-58 to 38", 128'(last_word[1]), 128'hC0DE_0026);
        set_req(1, 1, OP_WR_WORD, 100, 32'hD0D0_0004, '0); run_until(1, n);
        set_req(1, 0, 0, 0, '0, '0);
        dbg_force = 1; cyc(); dbg_force = -1;
        chk("R2", "100 to 4", 128'(last_dbg[31:0]), 128'hD0D0_0004);

        // R8: side-door write during a countdown
        set_req(0, 1, OP_RD_LINE, 8, '0, '0);
        n = 0;
        for (int c = 0; c < 20; c++) begin
            if (c == 1) set_req(2, 1, OP_WR_WORD, 0, 32'h5151_0000, '0);
            else        set_req(2, 0, 0, 0, '0, '0);
            cyc();
            if (c == 1) chk("R8", "side instant", 128'(last_ok[2]), 128'd1);
            if (last_ok[0]) break;
            n++;
        end
        chk("R8", "countdown undisturbed", 128'(n), 128'(DLY));
        set_req(0, 0, 0, 0, '0, '0); set_req(2, 0, 0, 0, '0, '0);
        dbg_force = 0; cyc(); dbg_force = -1;
        chk("R8", "side write landed", 128'(last_dbg[31:0]), 128'h5151_0000);

        // R8: side-door and owner write the same word on the same edge
        set_req(0, 1, OP_WR_WORD, 1, 32'hAAAA_0001, '0);
        for (int c = 0; c < 20; c++) begin
            if (c == DLY) set_req(2, 1, OP_WR_WORD, 1, 32'hBBBB_0001, '0);
            else          set_req(2, 0, 0, 0, '0, '0);
            cyc();
            if (last_ok[0]) break;
        end
        set_req(0, 0, 0, 0, '0, '0); set_req(2, 0, 0, 0, '0, '0);
        dbg_force = 0; cyc(); dbg_force = -1;
        chk("R8", "side wins collision", 128'(last_dbg[63:32]), 128'hBBBB_0001);

        // R11: read sees memory before a same-cycle write
        set_req(0, 1, OP_RD_WORD, 1, '0, '0);
        for (int c = 0; c < 20; c++) begin
            if (c == DLY) set_req(2, 1, OP_WR_WORD, 1, 32'hCCCC_0001, '0);
            else          set_req(2, 0, 0, 0, '0, '0);
            cyc();
            if (last_ok[0]) break;
        end
        chk("R11", "old data on collision", 128'(last_word[0]), 128'hBBBB_0001);
        set_req(0, 0, 0, 0, '0, '0); set_req(2, 0, 0, 0, '0, '0);
        cyc();

        // R4: zero-latency copy on the same stimulus
        set_req(0, 1, OP_WR_WORD, 7, 32'h7777_0007, '0);
        set_req(1, 1, OP_RD_WORD, 7, '0, '0);
        cyc();
        chk("R4", "same-cycle ok", 128'(last_zok), 128'b001);
        set_req(0, 0, 0, 0, '0, '0);
        cyc();
        chk("R4", "next port same cycle", 128'(last_zok[1]), 128'd1);
        chk("R4", "data after zero latency", 128'(last_zword1), 128'h7777_0007);
        set_req(0, 1, OP_WR_WORD, 7, 32'h7777_0007, '0);
        run_until(0, n);
        set_req(0, 0, 0, 0, '0, '0);
        run_until(1, n);
        set_req(1, 0, 0, 0, '0, '0);

        // mixed traffic against the model
        for (int c = 0; c < 300; c++) begin
            for (int p = 0; p < 2; p++) begin
                if (!req_valid[p] || last_ok[p]) begin
                    if (rnd() % 3 == 0) set_req(p, 0, 0, 0, '0, '0);
                    else set_req(p, 1, rnd() % 4, (rnd() % 200) - 100, 32'(rnd()),
                                 {32'(rnd()), 32'(rnd()), 32'(rnd()), 32'(rnd())});
                end
            end
            if (rnd() % 5 == 0) set_req(2, 1, rnd() % 4, (rnd() % 200) - 100, 32'(rnd()),
                                        {32'(rnd()), 32'(rnd()), 32'(rnd()), 32'(rnd())});
            else set_req(2, 0, 0, 0, '0, '0);
            cyc();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule